// File: doc/BRIEF.md
# Card Bus Access Lane Sequencer

This block sits between a processor load/store port and an external card socket bus. Each request carries an access size, a space type (common memory, attribute memory or I/O), an address, a direction and write data. The block decides the bus width of the target and rejects combinations that have no defined meaning. Otherwise it runs one or two bus cycles. For each cycle it drives an active-low enable pair, one for the low byte lane and one for the high byte lane, together with the address and the lane-steered write data.

A half-word aimed at an 8-bit target becomes two byte cycles on the low lane. The even byte goes first and the address steps by one for the second. Read data is gathered into a single result, and a one-clock `done` pulse, with `err` beside it for a rejected request, ends every request. Each bus cycle keeps its enables low for a fixed number of clocks, set by a parameter. Strobe shaping, wait states and socket power belong to neighbouring logic.

Top module: `card_lane_seq`

## Requirements
- R1: Memory space and attribute space are 16-bit targets. I/O space is 16-bit when `io16_n` is low and 8-bit otherwise. `io16_n` is sampled on the clock that accepts a request, and later changes do not affect that request.
- R2: A word access (size 2) with address bits [1:0] = 00 on a 16-bit target runs one cycle with both enables low. It moves all 32 data bits in either direction.
- R3: A word access at any other alignment, or to an 8-bit target, starts no bus cycle and returns `done` and `err` high together on the clock after acceptance.
- R4: A half-word access (size 1) at an even address on a 16-bit target runs one cycle with both enables low. Write data goes out on bus bits [15:0], and read data is returned in `rdata[15:0]` with the upper bits zero.
- R5: A half-word access at an even address on an 8-bit target runs two cycles, each with only `bus_ce_lo_n` low. The first cycle uses the request address and the second uses that address plus one. Writes send `wdata[7:0]` and then `wdata[15:8]`, both on bus bits [7:0]. Reads put the first byte in `rdata[7:0]` and the second in `rdata[15:8]`.
- R6: A half-word access at an odd address is rejected as in R3, whatever the bus width.
- R7: A byte access (size 0) on a 16-bit target with address bit 0 clear uses only `bus_ce_lo_n` and bus bits [7:0]. With address bit 0 set it uses only `bus_ce_hi_n` and bus bits [15:8]. Read bytes are always returned in `rdata[7:0]`.
- R8: A byte access on an 8-bit target uses only `bus_ce_lo_n` and bus bits [7:0] for either value of address bit 0.
- R9: Each bus cycle holds its enables low for exactly CYC_LEN clocks. `done` rises on the clock after the last cycle ends, and the enables are high while it is asserted. For a request accepted at clock edge k, `done` follows edge k+CYC_LEN for one cycle and edge k+2*CYC_LEN+1 for a split access, with `rdata` valid alongside it.
- R10: `req_valid` is ignored while a request is in progress. A request is accepted only while the block is idle.
- R11: Size code 3 and space code 3 are reserved. Space codes are 0 = memory, 1 = attribute and 2 = I/O. A request carrying a reserved code is rejected as in R3.
- R12: Address, write data and direction stay constant while an enable is low. `rdata` is zero after a write request or a rejected request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, accepted only when idle |
| req_size | input | 2 | 0 byte, 1 half-word, 2 word, 3 reserved |
| req_space | input | 2 | 0 memory, 1 attribute, 2 I/O, 3 reserved |
| req_addr | input | AW | Byte address |
| req_write | input | 1 | 1 store, 0 load |
| req_wdata | input | 32 | Store data, right-aligned |
| io16_n | input | 1 | Low when the I/O target is 16 bits wide |
| bus_ce_lo_n | output | 1 | Low-lane enable, active low |
| bus_ce_hi_n | output | 1 | High-lane enable, active low |
| bus_addr | output | AW | Bus cycle address |
| bus_wr | output | 1 | Bus cycle direction, 1 write |
| bus_wdata | output | 32 | Lane-steered write data |
| bus_rdata | input | 32 | Data returned by the target |
| done | output | 1 | One-clock completion pulse |
| err | output | 1 | Request rejected, with done |
| rdata | output | 32 | Gathered load result, valid with done |

## Verification
The bench drives a request just after a falling edge and counts falling edges from the accepting rising edge onward. A rejection must show `done` and `err` on the first of these falling edges. A single-cycle request must show `done` on falling edge CYC_LEN+1, and a split request on falling edge 2*CYC_LEN+2. At every falling edge in between, the bench records the enable pair, address, direction and write data of each bus cycle and counts how long each cycle lasts. These records are compared against a model computed from the request, and `rdata` is compared on the `done` sample. To show that `io16_n` and `req_valid` are ignored after acceptance, the bench changes them on the first falling edge after acceptance and still expects the outcome of the original request.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    SP_MEM  = 2'd0,
    SP_ATTR = 2'd1,
    SP_IO   = 2'd2,
    SP_RSVD = 2'd3
  } acc_space_e;

  typedef struct packed {
    logic bad;     // no defined bus operation
    logic split;   // two low-lane byte cycles
    logic use_lo;  // low-lane enable in first cycle
    logic use_hi;  // high-lane enable in first cycle
    logic upper;   // single byte on the high lane
  } lane_plan_t;
endpackage

// File: rtl/pcc_plan.sv
module pcc_plan
  import pcc_pkg::*;
(
  input  acc_size_e  size_i,
  input  acc_space_e space_i,
  input  logic [1:0] addr_lo_i,
  input  logic       io16_n_i,
  output lane_plan_t plan_o
);
  logic wide;

  always_comb begin
    wide   = (space_i == SP_MEM) || (space_i == SP_ATTR) ||
             ((space_i == SP_IO) && !io16_n_i);
    plan_o = '0;
    case (size_i)
      SZ_WORD: begin
        if (wide && (addr_lo_i == 2'b00)) begin
          plan_o.use_lo = 1'b1;
          plan_o.use_hi = 1'b1;
        end else begin
          plan_o.bad = 1'b1;
        end
      end
      SZ_HALF: begin
        if (addr_lo_i[0]) begin
          plan_o.bad = 1'b1;
        end else if (wide) begin
          plan_o.use_lo = 1'b1;
          plan_o.use_hi = 1'b1;
        end else begin
          plan_o.split  = 1'b1;
          plan_o.use_lo = 1'b1;
        end
      end
      SZ_BYTE: begin
        if (wide && addr_lo_i[0]) begin
          plan_o.use_hi = 1'b1;
          plan_o.upper  = 1'b1;
        end else begin
          plan_o.use_lo = 1'b1;
        end
      end
      default: plan_o.bad = 1'b1;
    endcase
    if (space_i == SP_RSVD) plan_o.bad = 1'b1;
    if (plan_o.bad) begin
      plan_o.split  = 1'b0;
      plan_o.use_lo = 1'b0;
      plan_o.use_hi = 1'b0;
      plan_o.upper  = 1'b0;
    end
  end
endmodule

// File: rtl/pcc_beat_timer.sv
module pcc_beat_timer #(
  parameter int LEN = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic last_o
);
  localparam int CW = (LEN > 1) ? $clog2(LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  logic [CW-1:0] cnt;
  logic          run;

  always_ff @(posedge clk) begin
    if (rst) begin
      run <= 1'b0;
      cnt <= '0;
    end else if (start_i) begin
      run <= 1'b1;
      cnt <= '0;
    end else if (run) begin
      if (cnt == LAST) run <= 1'b0;
      else             cnt <= cnt + 1'b1;
    end
  end

  assign last_o = run && (cnt == LAST);
endmodule

// File: rtl/pcc_lane_steer.sv
module pcc_lane_steer
  import pcc_pkg::*;
(
  input  acc_size_e   size_i,
  input  logic        split_i,
  input  logic        upper_i,
  input  logic        beat_i,
  input  logic [31:0] wdata_i,
  input  logic [31:0] bus_rdata_i,
  input  logic [31:0] rdata_cur_i,
  output logic [31:0] bus_wdata_o,
  output logic [31:0] rdata_next_o
);
  always_comb begin
    if (size_i == SZ_WORD) begin
      bus_wdata_o  = wdata_i;
      rdata_next_o = bus_rdata_i;
    end else if (split_i) begin
      bus_wdata_o  = beat_i ? {24'd0, wdata_i[15:8]} : {24'd0, wdata_i[7:0]};
      rdata_next_o = beat_i ? {16'd0, bus_rdata_i[7:0], rdata_cur_i[7:0]}
                            : {24'd0, bus_rdata_i[7:0]};
    end else if (size_i == SZ_HALF) begin
      bus_wdata_o  = {16'd0, wdata_i[15:0]};
      rdata_next_o = {16'd0, bus_rdata_i[15:0]};
    end else if (upper_i) begin
      bus_wdata_o  = {16'd0, wdata_i[7:0], 8'd0};
      rdata_next_o = {24'd0, bus_rdata_i[15:8]};
    end else begin
      bus_wdata_o  = {24'd0, wdata_i[7:0]};
      rdata_next_o = {24'd0, bus_rdata_i[7:0]};
    end
  end
endmodule

// File: rtl/card_lane_seq.sv
module card_lane_seq
  import pcc_pkg::*;
#(
  parameter int AW      = 26,
  parameter int CYC_LEN = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [1:0]    req_size,
  input  logic [1:0]    req_space,
  input  logic [AW-1:0] req_addr,
  input  logic          req_write,
  input  logic [31:0]   req_wdata,
  input  logic          io16_n,
  output logic          bus_ce_lo_n,
  output logic          bus_ce_hi_n,
  output logic [AW-1:0] bus_addr,
  output logic          bus_wr,
  output logic [31:0]   bus_wdata,
  input  logic [31:0]   bus_rdata,
  output logic          done,
  output logic          err,
  output logic [31:0]   rdata
);
  typedef enum logic [1:0] {ST_IDLE, ST_ACT, ST_GAP} seq_state_e;

  seq_state_e  state;
  lane_plan_t  plan_live;
  acc_size_e   size_q, size_s;
  logic        split_q, upper_q, beat_q, wr_q;
  logic        split_s, upper_s, beat_s;
  logic [31:0] wdata_q, wdata_s, wd_steer, rd_next;
  logic        accept, t_start, t_last;

  pcc_plan u_plan (
    .size_i    (acc_size_e'(req_size)),
    .space_i   (acc_space_e'(req_space)),
    .addr_lo_i (req_addr[1:0]),
    .io16_n_i  (io16_n),
    .plan_o    (plan_live)
  );

  assign accept  = (state == ST_IDLE) && req_valid;
  assign t_start = (accept && !plan_live.bad) || (state == ST_GAP);

  pcc_beat_timer #(.LEN(CYC_LEN)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .start_i (t_start),
    .last_o  (t_last)
  );

  assign size_s  = (state == ST_IDLE) ? acc_size_e'(req_size) : size_q;
  assign split_s = (state == ST_IDLE) ? plan_live.split : split_q;
  assign upper_s = (state == ST_IDLE) ? plan_live.upper : upper_q;
  assign wdata_s = (state == ST_IDLE) ? req_wdata : wdata_q;
  assign beat_s  = (state == ST_GAP) || beat_q;

  pcc_lane_steer u_steer (
    .size_i       (size_s),
    .split_i      (split_s),
    .upper_i      (upper_s),
    .beat_i       (beat_s),
    .wdata_i      (wdata_s),
    .bus_rdata_i  (bus_rdata),
    .rdata_cur_i  (rdata),
    .bus_wdata_o  (wd_steer),
    .rdata_next_o (rd_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      size_q      <= SZ_BYTE;
      split_q     <= 1'b0;
      upper_q     <= 1'b0;
      beat_q      <= 1'b0;
      wr_q        <= 1'b0;
      wdata_q     <= '0;
      bus_ce_lo_n <= 1'b1;
      bus_ce_hi_n <= 1'b1;
      bus_addr    <= '0;
      bus_wr      <= 1'b0;
      bus_wdata   <= '0;
      done        <= 1'b0;
      err         <= 1'b0;
      rdata       <= '0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            rdata <= '0;
            if (plan_live.bad) begin
              done <= 1'b1;
              err  <= 1'b1;
            end else begin
              size_q      <= acc_size_e'(req_size);
              split_q     <= plan_live.split;
              upper_q     <= plan_live.upper;
              beat_q      <= 1'b0;
              wr_q        <= req_write;
              wdata_q     <= req_wdata;
              bus_ce_lo_n <= !plan_live.use_lo;
              bus_ce_hi_n <= !plan_live.use_hi;
              bus_addr    <= req_addr;
              bus_wr      <= req_write;
              bus_wdata   <= wd_steer;
              state       <= ST_ACT;
            end
          end
        end
        ST_ACT: begin
          if (t_last) begin
            bus_ce_lo_n <= 1'b1;
            bus_ce_hi_n <= 1'b1;
            if (!wr_q) rdata <= rd_next;
            if (split_q && !beat_q) begin
              beat_q   <= 1'b1;
              bus_addr <= bus_addr + 1'b1;
              state    <= ST_GAP;
            end else begin
              beat_q <= 1'b0;
              done   <= 1'b1;
              state  <= ST_IDLE;
            end
          end
        end
        ST_GAP: begin
          bus_ce_lo_n <= 1'b0;
          bus_wdata   <= wd_steer;
          state       <= ST_ACT;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pcc_chk.sv
module pcc_chk #(
  parameter int AW = 26
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_ce_lo_n,
  input logic          bus_ce_hi_n,
  input logic [AW-1:0] bus_addr,
  input logic          bus_wr,
  input logic [31:0]   bus_wdata,
  input logic          done,
  input logic          err
);
  logic any_low;
  assign any_low = !bus_ce_lo_n || !bus_ce_hi_n;

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (bus_ce_lo_n && bus_ce_hi_n));

  // R3
  err_done_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> done);

  // R12
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (any_low && $past(any_low)) |-> $stable(bus_addr));

  // R12
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (any_low && $past(any_low)) |-> ($stable(bus_wdata) && $stable(bus_wr)));

  // R8
  lower_lane_chk: assert property (@(posedge clk) disable iff (rst)
    (!bus_ce_lo_n && bus_ce_hi_n && bus_wr) |-> (bus_wdata[31:8] == 24'd0));
endmodule

bind card_lane_seq pcc_chk #(.AW(AW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .bus_ce_lo_n (bus_ce_lo_n),
  .bus_ce_hi_n (bus_ce_hi_n),
  .bus_addr    (bus_addr),
  .bus_wr      (bus_wr),
  .bus_wdata   (bus_wdata),
  .done        (done),
  .err         (err)
);

// File: tb/tb_card_lane_seq.sv
module tb_card_lane_seq;
  localparam int AW = 26;
  localparam int CL = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic [1:0]    req_size = '0, req_space = '0;
  logic [AW-1:0] req_addr = '0;
  logic          req_write = 1'b0;
  logic [31:0]   req_wdata = '0;
  logic          io16_n = 1'b1;
  logic          bus_ce_lo_n, bus_ce_hi_n, bus_wr, done, err;
  logic [AW-1:0] bus_addr;
  logic [31:0]   bus_wdata, bus_rdata, rdata;
  int checks = 0;
  int errs = 0;

  always #10 clk = ~clk;

  function automatic logic [31:0] mdl(input logic [AW-1:0] a);
    return {a[7:0] ^ 8'h3C, a[7:0] + 8'd91, a[7:0] ^ 8'hA5, ~a[7:0]};
  endfunction

  assign bus_rdata = mdl(bus_addr);

  card_lane_seq #(.AW(AW), .CYC_LEN(CL)) dut (.*);

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic run_req(input logic [1:0] sz, input logic [1:0] sp,
                         input logic [AW-1:0] a, input bit wr,
                         input logic [31:0] wd, input bit i16n, input bit junk);
    bit wide, bad, upper, split;
    int nb, exp_n, done_n, beats;
    logic [1:0]    exp_ce;
    logic [31:0]   exp_wd[2];
    logic [31:0]   exp_rd;
    logic [1:0]    ob_ce[2];
    logic [AW-1:0] ob_ad[2];
    logic [31:0]   ob_wd[2];
    logic          ob_wr[2];
    int            ob_len[2];
    bit            prev_low, got_err;
    logic [31:0]   got_rd;
    string         tag;

    wide  = (sp == 2'd0) || (sp == 2'd1) || ((sp == 2'd2) && !i16n);
    bad   = (sp == 2'd3) || (sz == 2'd3) ||
            ((sz == 2'd2) && !(wide && a[1:0] == 2'b00)) ||
            ((sz == 2'd1) && a[0]);
    split = !bad && (sz == 2'd1) && !wide;
    upper = (sz == 2'd0) && wide && a[0];
    nb    = bad ? 0 : (split ? 2 : 1);
    exp_n = bad ? 1 : (split ? 2*CL + 2 : CL + 1);
    exp_ce = (sz != 2'd0 && !split) ? 2'b00 : (upper ? 2'b01 : 2'b10);
    exp_wd[1] = {24'd0, wd[15:8]};
    if (sz == 2'd2)     exp_wd[0] = wd;
    else if (split)     exp_wd[0] = {24'd0, wd[7:0]};
    else if (sz == 2'd1) exp_wd[0] = {16'd0, wd[15:0]};
    else if (upper)     exp_wd[0] = {16'd0, wd[7:0], 8'd0};
    else                exp_wd[0] = {24'd0, wd[7:0]};
    if (wr || bad)       exp_rd = '0;
    else if (sz == 2'd2) exp_rd = mdl(a);
    else if (split)      exp_rd = {16'd0, mdl(a + 1'b1)[7:0], mdl(a)[7:0]};
    else if (sz == 2'd1) exp_rd = {16'd0, mdl(a)[15:0]};
    else if (upper)      exp_rd = {24'd0, mdl(a)[15:8]};
    else                 exp_rd = {24'd0, mdl(a)[7:0]};

    if (junk) tag = "R10";
    else if (sp == 2'd3 || sz == 2'd3) tag = "R11";
    else if (sz == 2'd2) tag = bad ? "R3" : "R2";
    else if (sz == 2'd1) tag = bad ? "R6" : (split ? "R5" : "R4");
    else tag = wide ? "R7" : "R8";
    if (sp == 2'd2 && !bad) tag = {tag, "/R1"};

    @(negedge clk);
    req_valid = 1'b1; req_size = sz; req_space = sp; req_addr = a;
    req_write = wr; req_wdata = wd; io16_n = i16n;
    @(negedge clk);
    io16_n = ~i16n;
    if (junk) begin
      req_size = 2'd2; req_space = 2'd0; req_addr = ~a; req_write = ~wr;
      req_wdata = ~wd;
    end else begin
      req_valid = 1'b0;
    end
    beats = 0; done_n = 0; prev_low = 0; got_err = 0; got_rd = '0;
    for (int n = 1; n <= 40; n++) begin
      if (!bus_ce_lo_n || !bus_ce_hi_n) begin
        if (!prev_low) begin
          if (beats < 2) begin
            ob_ce[beats] = {bus_ce_hi_n, bus_ce_lo_n};
            ob_ad[beats] = bus_addr;
            ob_wd[beats] = bus_wdata;
            ob_wr[beats] = bus_wr;
            ob_len[beats] = 1;
          end
          beats++;
        end else if (beats <= 2) begin
          ob_len[beats-1]++;
        end
        prev_low = 1;
      end else begin
        prev_low = 0;
      end
      if (done) begin
        done_n = n; got_err = err; got_rd = rdata;
        req_valid = 1'b0;
        break;
      end
      @(negedge clk);
    end
    req_valid = 1'b0;

    chk(done_n == exp_n, tag, "R9 done timing", 32'(done_n), 32'(exp_n));
    chk(got_err == bad, tag, "error flag", 32'(got_err), 32'(bad));
    chk(beats == nb, tag, "bus cycle count", 32'(beats), 32'(nb));
    if (beats == nb) begin
      for (int b = 0; b < nb; b++) begin
        chk(ob_ce[b] == exp_ce, tag, "enable pair {hi,lo}", 32'(ob_ce[b]), 32'(exp_ce));
        chk(ob_ad[b] == a + AW'(b), tag, "R12 cycle address", 32'(ob_ad[b]), 32'(a + AW'(b)));
        chk(ob_len[b] == CL, tag, "R9 cycle length", 32'(ob_len[b]), 32'(CL));
        chk(ob_wr[b] == wr, tag, "direction", 32'(ob_wr[b]), 32'(wr));
        if (wr) chk(ob_wd[b] == exp_wd[b], tag, "write lanes", ob_wd[b], exp_wd[b]);
      end
    end
    chk(got_rd == exp_rd, tag, "R12 read result", got_rd, exp_rd);
  endtask

  initial begin
    #(20 * 150000);
    errs++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(bus_ce_lo_n && bus_ce_hi_n, "R9", "reset enables high", 32'({bus_ce_hi_n, bus_ce_lo_n}), 32'd3);
    chk(!done && !err, "R9", "reset done/err low", 32'({done, err}), 32'd0);

    // directed corner cases
    run_req(2'd2, 2'd0, 26'h0001000, 1'b0, 32'h0, 1'b1, 1'b0);        // R2 word read
    run_req(2'd2, 2'd1, 26'h0002004, 1'b1, 32'hDEADBEEF, 1'b1, 1'b0); // R2 word write
    run_req(2'd2, 2'd0, 26'h0000002, 1'b0, 32'h0, 1'b0, 1'b0);        // R3 misaligned
    run_req(2'd2, 2'd2, 26'h0000010, 1'b1, 32'h1, 1'b1, 1'b0);        // R3 8-bit I/O
    run_req(2'd2, 2'd2, 26'h0000010, 1'b0, 32'h1, 1'b0, 1'b0);        // R1 16-bit I/O word
    run_req(2'd1, 2'd0, 26'h0000031, 1'b0, 32'h0, 1'b0, 1'b0);        // R6 odd half
    run_req(2'd1, 2'd2, 26'h00000F3, 1'b1, 32'h0, 1'b1, 1'b0);        // R6 odd half 8-bit
    run_req(2'd1, 2'd1, 26'h0000046, 1'b1, 32'h0000A55A, 1'b1, 1'b0); // R4
    run_req(2'd1, 2'd2, 26'h00000FE, 1'b0, 32'h0, 1'b1, 1'b0);        // R5 split read
    run_req(2'd1, 2'd2, 26'h0000120, 1'b1, 32'h00003412, 1'b1, 1'b0); // R5 split write
    run_req(2'd0, 2'd0, 26'h0000077, 1'b1, 32'h000000C9, 1'b1, 1'b0); // R7 upper lane
    run_req(2'd0, 2'd0, 26'h0000077, 1'b0, 32'h0, 1'b1, 1'b0);        // R7 upper read
    run_req(2'd0, 2'd2, 26'h0000077, 1'b0, 32'h0, 1'b1, 1'b0);        // R8 odd on 8-bit
    run_req(2'd3, 2'd0, 26'h0000000, 1'b0, 32'h0, 1'b0, 1'b0);        // R11 size
    run_req(2'd0, 2'd3, 26'h0000000, 1'b0, 32'h0, 1'b0, 1'b0);        // R11 space
    run_req(2'd1, 2'd2, 26'h0000200, 1'b0, 32'h0, 1'b1, 1'b1);        // R10 during split
    run_req(2'd0, 2'd2, 26'h0000301, 1'b1, 32'h5E, 1'b0, 1'b1);       // R10, R1

    // constrained random
    for (int i = 0; i < 400; i++) begin
      logic [1:0] sz, sp;
      sz = 2'($urandom_range(0, 7) < 7 ? $urandom_range(0, 2) : 3);
      sp = 2'($urandom_range(0, 7) < 7 ? $urandom_range(0, 2) : 3);
      run_req(sz, sp, AW'($urandom), 1'($urandom), $urandom,
              1'($urandom), ($urandom_range(0, 3) == 0));
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule